// File: doc/BRIEF.md
# Block Lock Register Bank

This block holds a small lock register for every block of a flash array. Each register carries three flags: a write lock, a lockdown flag and a read lock. A byte-wide host port reaches the registers. The block index comes from the address bits above the block stride, and the register sits at byte offset 2 inside each block's window. The bank drives a write-inhibit line and a read-inhibit line for each block, and the array logic uses these lines to gate program, erase and read operations.

Each register is a small state machine with one state for each combination of the three flags. The states that have lockdown set accept no writes, so a locked-down block keeps its current lock combination until the next reset. After reset every block is write-locked, read-enabled and free of lockdown. The number of blocks, the stride (as a power of two) and the address width are parameters.

States of each register cell, named with the register value they read back as:
- LK_OPEN (0): full access.
- LK_WR (1): write-locked. This is the reset state.
- LK_OPEN_HELD (2): full access, locked down.
- LK_WR_HELD (3): write-locked and locked down.
- LK_RD (4): read-locked.
- LK_RDWR (5): read- and write-locked.
- LK_RD_HELD (6): read-locked and locked down.
- LK_ALL_HELD (7): every flag set.

Transitions: reset takes any state to LK_WR. From LK_OPEN, LK_WR, LK_RD and LK_RDWR, a write to the cell goes to the state whose code equals bits 2:0 of the write data. Every other cycle leaves the state unchanged, and so does any write while the cell is in one of the four HELD states.

Top module: `lockreg_bank`

## Requirements
- R1: When reset is released, every block's register reads 0x01, every write_inhibit bit is 1 and every read_inhibit bit is 0.
- R2: A register is selected only when address bits [STRIDE_LOG2-1:0] equal 2 and the index addr >> STRIDE_LOG2 is below NUM_BLOCKS. Writes to any other address change nothing, and reads of any other address return 0x00.
- R3: Bit 0 is the write lock, bit 1 is lockdown and bit 2 is the read lock. A write to a register that does not have lockdown set loads bits 2:0 of the data, so any of the codes 0 to 7 can be stored.
- R4: Write data bits 7:3 are ignored, and rd_data bits 7:3 always read 0.
- R5: While bit 1 of a register is set, writes to it leave all three bits unchanged. Lockdown cannot be cleared by a write.
- R6: write_inhibit[i] equals bit 0 of register i and read_inhibit[i] equals bit 2. Both follow a write from the clock edge that accepts it.
- R7: rd_data loads on each clock edge where rd_en is 1, taking the value the addressed register held before that edge (a write in the same cycle is not yet visible). It holds its value while rd_en is 0.
- R8: A write changes only the addressed block's register.
- R9: Reset returns every register, including those locked down, to 0x01, and afterwards the registers accept writes again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Byte address shared by reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| write_inhibit | output | NUM_BLOCKS | Per-block write-inhibit line (bit 0 of the register) |
| read_inhibit | output | NUM_BLOCKS | Per-block read-inhibit line (bit 2 of the register) |

## Verification
The bench builds the bank with NUM_BLOCKS=5, STRIDE_LOG2=4 and ADDR_W=7. With these values each register window is 16 bytes, so the tests can reach wrong offsets and the register offset in a few directed accesses. Because five blocks is not a power of two, indices 5 to 7 are valid address patterns that map to no block, which exercises the range check in the decoder. Five blocks also leave enough room to put different blocks into the held states while the other blocks keep accepting writes.

// File: rtl/lockreg_pkg.sv
package lockreg_pkg;

    localparam int FIELD_W  = 3;
    localparam int BYTE_W   = 8;
    localparam int WL_BIT   = 0;
    localparam int LD_BIT   = 1;
    localparam int RL_BIT   = 2;
    localparam int LOCK_OFS = 2;

    typedef enum logic [FIELD_W-1:0] {
        LK_OPEN      = 3'd0,
        LK_WR        = 3'd1,
        LK_OPEN_HELD = 3'd2,
        LK_WR_HELD   = 3'd3,
        LK_RD        = 3'd4,
        LK_RDWR      = 3'd5,
        LK_RD_HELD   = 3'd6,
        LK_ALL_HELD  = 3'd7
    } lock_state_e;

    localparam lock_state_e LK_RESET = LK_WR;

endpackage

// File: rtl/lockreg_decode.sv
module lockreg_decode
    import lockreg_pkg::*;
#(
    parameter int NUM_BLOCKS  = 8,
    parameter int STRIDE_LOG2 = 16,
    parameter int ADDR_W      = 19
) (
    input  logic [ADDR_W-1:0]     addr,
    output logic [NUM_BLOCKS-1:0] blk_sel
);
    localparam int BLK_W = ADDR_W - STRIDE_LOG2;

    logic [BLK_W-1:0] blk_idx;
    logic             ofs_hit;
    logic             range_hit;

    assign blk_idx   = addr[ADDR_W-1:STRIDE_LOG2];
    assign ofs_hit   = (addr[STRIDE_LOG2-1:0] == STRIDE_LOG2'(LOCK_OFS));
    assign range_hit = ({1'b0, blk_idx} < (BLK_W+1)'(NUM_BLOCKS));

    for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_sel
        assign blk_sel[i] = ofs_hit && range_hit && (blk_idx == BLK_W'(i));
    end

endmodule

// File: rtl/lockreg_cell.sv
module lockreg_cell
    import lockreg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_hit,
    input  logic [FIELD_W-1:0] wr_field,
    output logic [FIELD_W-1:0] lock_bits,
    output logic               wr_inhibit,
    output logic               rd_inhibit
);
    lock_state_e state_q;
    lock_state_e state_d;
    logic        held;

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN, LK_WR, LK_RD, LK_RDWR: begin
                if (wr_hit) state_d = lock_state_e'(wr_field);
            end
            LK_OPEN_HELD, LK_WR_HELD, LK_RD_HELD, LK_ALL_HELD: begin
                state_d = state_q;
            end
            default: state_d = LK_RESET;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= LK_RESET;
        else     state_q <= state_d;
    end

    // outputs
    always_comb begin
        wr_inhibit = 1'b0;
        rd_inhibit = 1'b0;
        held       = 1'b0;
        unique case (state_q)
            LK_OPEN:      ;
            LK_WR:        wr_inhibit = 1'b1;
            LK_OPEN_HELD: held = 1'b1;
            LK_WR_HELD:   begin wr_inhibit = 1'b1; held = 1'b1; end
            LK_RD:        rd_inhibit = 1'b1;
            LK_RDWR:      begin wr_inhibit = 1'b1; rd_inhibit = 1'b1; end
            LK_RD_HELD:   begin rd_inhibit = 1'b1; held = 1'b1; end
            LK_ALL_HELD:  begin wr_inhibit = 1'b1; rd_inhibit = 1'b1; held = 1'b1; end
            default:      ;
        endcase
    end

    always_comb begin
        lock_bits         = '0;
        lock_bits[WL_BIT] = wr_inhibit;
        lock_bits[LD_BIT] = held;
        lock_bits[RL_BIT] = rd_inhibit;
    end

endmodule

// File: rtl/lockreg_rdmux.sv
module lockreg_rdmux
    import lockreg_pkg::*;
#(
    parameter int NUM_BLOCKS = 8
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 rd_en,
    input  logic [NUM_BLOCKS-1:0]                blk_sel,
    input  logic [NUM_BLOCKS-1:0][FIELD_W-1:0]   lock_bits,
    output logic [BYTE_W-1:0]                    rd_data
);
    logic [FIELD_W-1:0] field_mux;

    always_comb begin
        field_mux = '0;
        for (int i = 0; i < NUM_BLOCKS; i++) begin
            if (blk_sel[i]) field_mux = field_mux | lock_bits[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= {{(BYTE_W-FIELD_W){1'b0}}, field_mux};
    end

endmodule

// File: rtl/lockreg_bank.sv
module lockreg_bank
    import lockreg_pkg::*;
#(
    parameter int NUM_BLOCKS  = 8,
    parameter int STRIDE_LOG2 = 16,
    parameter int ADDR_W      = STRIDE_LOG2 + $clog2(NUM_BLOCKS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  wr_en,
    input  logic [7:0]            wr_data,
    input  logic                  rd_en,
    output logic [7:0]            rd_data,
    output logic [NUM_BLOCKS-1:0] write_inhibit,
    output logic [NUM_BLOCKS-1:0] read_inhibit
);
    logic [NUM_BLOCKS-1:0]              blk_sel;
    logic [NUM_BLOCKS-1:0][FIELD_W-1:0] lock_bits;

    lockreg_decode #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .STRIDE_LOG2(STRIDE_LOG2),
        .ADDR_W     (ADDR_W)
    ) u_dec (
        .addr   (addr),
        .blk_sel(blk_sel)
    );

    for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_cell
        lockreg_cell u_cell (
            .clk       (clk),
            .rst       (rst),
            .wr_hit    (wr_en && blk_sel[i]),
            .wr_field  (wr_data[FIELD_W-1:0]),
            .lock_bits (lock_bits[i]),
            .wr_inhibit(write_inhibit[i]),
            .rd_inhibit(read_inhibit[i])
        );
    end

    lockreg_rdmux #(
        .NUM_BLOCKS(NUM_BLOCKS)
    ) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .blk_sel  (blk_sel),
        .lock_bits(lock_bits),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/lockreg_bank_chk.sv
module lockreg_bank_chk
    import lockreg_pkg::*;
#(
    parameter int NUM_BLOCKS  = 8,
    parameter int STRIDE_LOG2 = 16,
    parameter int ADDR_W      = 19
) (
    input logic                              clk,
    input logic                              rst,
    input logic [ADDR_W-1:0]                 addr,
    input logic                              wr_en,
    input logic                              rd_en,
    input logic [7:0]                        rd_data,
    input logic [NUM_BLOCKS-1:0][FIELD_W-1:0] lock_bits
);
    // R4: upper read bits are always zero
    p_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
        rd_data[7:3] == 5'd0);

    // R7: read data holds without a read strobe
    p_rd_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    // R8: no write, no change anywhere
    p_no_write_r8: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(lock_bits));

    // R2: writes at a wrong offset change nothing
    p_bad_ofs_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr[STRIDE_LOG2-1:0] != STRIDE_LOG2'(LOCK_OFS)) |=> $stable(lock_bits));

    for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_blk
        // R5: a locked-down register is frozen
        p_frozen_r5: assert property (@(posedge clk) disable iff (rst)
            lock_bits[i][LD_BIT] |=> $stable(lock_bits[i]));
    end

endmodule

bind lockreg_bank lockreg_bank_chk #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .STRIDE_LOG2(STRIDE_LOG2),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .lock_bits(lock_bits)
);

// File: tb/sim_lockreg_bank.sv
`timescale 1ns/1ps
module sim_lockreg_bank;
    localparam int NB = 5;
    localparam int SL = 4;
    localparam int AW = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_data = '0;
    logic          rd_en = 1'b0;
    logic [7:0]    rd_data;
    logic [NB-1:0] write_inhibit;
    logic [NB-1:0] read_inhibit;

    int checks = 0;
    int fails  = 0;
    int exp_q[NB];

    always #10 clk = ~clk;

    lockreg_bank #(.NUM_BLOCKS(NB), .STRIDE_LOG2(SL), .ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data),
        .write_inhibit(write_inhibit), .read_inhibit(read_inhibit)
    );

    function automatic logic [AW-1:0] reg_addr(int blk, int ofs);
        return AW'(blk * (1 << SL) + ofs);
    endfunction

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic check_all(string req);
        logic [7:0] d;
        logic [NB-1:0] ew, er;
        for (int b = 0; b < NB; b++) begin
            rd(reg_addr(b, 2), d);
            check(req, d, exp_q[b], $sformatf("read block %0d", b));
            ew[b] = exp_q[b][0];
            er[b] = exp_q[b][2];
        end
        check(req, write_inhibit, ew, "write_inhibit");
        check(req, read_inhibit, er, "read_inhibit");
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int b = 0; b < NB; b++) exp_q[b] = 1;
    endtask

    task automatic t_reset();
        do_reset();
        check_all("R1");
    endtask

    task automatic t_codes();
        int codes[4] = '{0, 4, 5, 1};
        foreach (codes[k]) begin
            wr(reg_addr(0, 2), 8'(codes[k]));
            exp_q[0] = codes[k];
            check("R6", write_inhibit[0], codes[k] & 1, "wi after write");
            check("R6", read_inhibit[0], (codes[k] >> 2) & 1, "ri after write");
            check_all("R3");
        end
    endtask

    task automatic t_upper();
        logic [7:0] d;
        wr(reg_addr(1, 2), 8'hF8);
        exp_q[1] = 0;
        rd(reg_addr(1, 2), d);
        check("R4", d, 0, "bits 7:3 ignored, code 0");
        wr(reg_addr(1, 2), 8'hFC);
        exp_q[1] = 4;
        rd(reg_addr(1, 2), d);
        check("R4", d, 4, "bits 7:3 ignored, code 4");
    endtask

    task automatic t_decode();
        logic [7:0] d;
        wr(reg_addr(2, 0), 8'h00);
        wr(reg_addr(2, 3), 8'h00);
        wr(reg_addr(5, 2), 8'h00);
        wr(reg_addr(7, 2), 8'h00);
        check_all("R2");
        rd(reg_addr(6, 2), d);
        check("R2", d, 0, "read of unmapped index");
        rd(reg_addr(3, 1), d);
        check("R2", d, 0, "read of wrong offset");
        wr(reg_addr(3, 2), 8'h00);
        exp_q[3] = 0;
        check_all("R8");
    endtask

    task automatic t_lockdown();
        wr(reg_addr(4, 2), 8'h06);
        exp_q[4] = 6;
        wr(reg_addr(4, 2), 8'h00);
        wr(reg_addr(4, 2), 8'h01);
        wr(reg_addr(2, 2), 8'h03);
        exp_q[2] = 3;
        wr(reg_addr(2, 2), 8'h00);
        wr(reg_addr(0, 2), 8'h02);
        exp_q[0] = 2;
        wr(reg_addr(0, 2), 8'h05);
        check_all("R5");
    endtask

    task automatic t_rdhold();
        logic [7:0] d;
        rd(reg_addr(1, 2), d);
        check("R7", d, exp_q[1], "read value");
        repeat (3) @(negedge clk);
        check("R7", rd_data, exp_q[1], "held without rd_en");
        @(negedge clk);
        addr = reg_addr(1, 2); rd_en = 1'b1; wr_en = 1'b1; wr_data = 8'h05;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        check("R7", rd_data, exp_q[1], "read sees pre-write value");
        exp_q[1] = 5;
        rd(reg_addr(1, 2), d);
        check("R7", d, 5, "read after write");
    endtask

    task automatic t_reset_again();
        logic [7:0] d;
        do_reset();
        check_all("R9");
        wr(reg_addr(4, 2), 8'h00);
        rd(reg_addr(4, 2), d);
        check("R9", d, 0, "writable after reset");
    endtask

    initial begin
        t_reset();
        t_codes();
        t_upper();
        t_decode();
        t_lockdown();
        t_rdhold();
        t_reset_again();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule